// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which low-power state a small single-chip microcontroller is in, and from that state it drives the clock enables and synchronous resets of the CPU and the on-chip peripherals. A single CPU strobe signals that a sleep instruction has executed. A standby-select control bit sampled with that strobe decides what happens next. If the bit is clear, only the CPU stops. If the bit is set, everything stops and the peripherals are held in reset. An active-low standby pin forces a deep standby from any state. In deep standby the I/O ports float and the system clock output pin is released. A separate register holds one standby bit per peripheral. Setting a bit stops and resets that peripheral while the CPU keeps running.

The reset pin, the standby pin, NMI and the three external interrupt requests each pass through a two-flop synchronizer. The reset pin asserts the block reset at once and releases it in step with the clock. Reset has the highest priority, the standby pin comes next, and wake sources come last. When the block wakes from software standby, it waits for a programmable settling count with the clock running, then returns to run. The global mode is shown on a 3-bit status output.

Top module: `lowpower_mode_ctrl`

## Requirements
- R1: While `rstPinN` is low, `mode` is 4 (reset) with no clock delay, `modStbyQ` is 0, `cpuClkEn` is 0, every `modRst` bit is 1 and `refFullRst` is 1. After `rstPinN` rises, `mode` becomes 0 (run) on the third rising clock edge and not before.
- R2: A `sleepInsn` pulse in run with `ssbySel` = 0 gives `mode` 1 (sleep) on the next edge. In sleep, `cpuClkEn` is 0, `modClkEn` equals the inverse of `modStbyQ`, `refClkEn` is 1, `sysClkOe` is 1 and `sysClkHigh` is 0.
- R3: Sleep returns to run one edge after `intPend` is high. It also returns to run on the third edge after `nmiIn` or any `irqIn` bit rises. No other input ends sleep.
- R4: A `sleepInsn` pulse in run with `ssbySel` = 1 gives `mode` 2 (software standby) on the next edge. In software standby all `modClkEn` bits are 0, all `modRst` bits are 1, `refPartRst` is 1, `refFullRst` is 0, `sysClkOe` is 1 and `sysClkHigh` is 1.
- R5: Software standby ignores `intPend` and `sleepInsn`. Only `nmiIn` or an `irqIn` bit wakes it.
- R6: A wake from software standby enters `mode` 5 (settling) on the third edge after the wake input rises. The block stays there for exactly `settleCnt` cycles, then enters run. A `settleCnt` of 0 counts as 1.
- R7: A low `stbyPinN` gives `mode` 3 (hardware standby) on the third edge after it falls, from run, sleep, software standby or settling. In hardware standby `portHiZ` is 1, `sysClkOe` is 0, `refFullRst` is 1, `cpuClkEn` is 0 and all `modClkEn` bits are 0.
- R8: Hardware standby ignores NMI, IRQ and `intPend`. On the third edge after `stbyPinN` rises, `mode` becomes 4. One edge later `mode` becomes 0, and by then `modStbyQ` has been cleared.
- R9: In run, a `modStbyWe` pulse loads `modStbyWd` into `modStbyQ` on the next edge. In run and in sleep, a set bit i gives `modClkEn[i]` = 0 and `modRst[i]` = 1, and a clear bit gives the opposite. `cpuClkEn` stays 1 in run.
- R10: A `modStbyWe` pulse in any mode other than run leaves `modStbyQ` unchanged.
- R11: Reset overrides the standby pin: a low `rstPinN` gives `mode` 4 even while in hardware standby. The standby pin overrides wake sources: NMI and a low `stbyPinN` arriving together in software standby lead to `mode` 3, not 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPinN | input | 1 | Active-low reset pin |
| stbyPinN | input | 1 | Active-low hardware standby pin |
| nmiIn | input | 1 | Non-maskable interrupt request |
| irqIn | input | 3 | External interrupt requests 0 to 2 |
| intPend | input | 1 | Any interrupt pending (CPU clock domain) |
| sleepInsn | input | 1 | One-cycle strobe: sleep instruction executed |
| ssbySel | input | 1 | Standby select: 0 = sleep, 1 = software standby |
| settleCnt | input | 8 | Settling cycles after software-standby wake |
| modStbyWe | input | 1 | Write strobe for the module standby register |
| modStbyWd | input | 6 | Write data for the module standby register |
| cpuClkEn | output | 1 | CPU clock enable |
| modClkEn | output | 6 | Per-peripheral clock enables |
| modRst | output | 6 | Per-peripheral synchronous resets |
| refClkEn | output | 1 | Refresh controller clock enable |
| refPartRst | output | 1 | Clears refresh counter and top status bits only |
| refFullRst | output | 1 | Full refresh controller reset |
| sysClkOe | output | 1 | System clock output pin enable (0 = high impedance) |
| sysClkHigh | output | 1 | Hold system clock output pin high |
| portHiZ | output | 1 | Put I/O ports in high impedance |
| modStbyQ | output | 6 | Module standby register contents |
| mode | output | 3 | Global mode: 0 run, 1 sleep, 2 sw standby, 3 hw standby, 4 reset, 5 settling |

## Verification
Entry into sleep and software standby is driven with the same strobe, and only the select bit differs, so the two paths are checked as different outcomes of one trigger. The two standby modes are then tried with the same wake patterns. An `intPend` pulse must end sleep but leave software standby alone, and NMI or IRQ must end both. These cases show whether each mode has its own wake-source set. The standby pin is pulled low from run, from sleep and from software standby, together with a wake request. The reset pin is pulled low during hardware standby. Together these cases pin down the priority order. The settling count is tried at 4 and at 0, and each synchronized input is sampled one edge before and on the edge it must act, which shows whether the counter boundaries and the two-flop latency are right.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IRQ_W = 3;

  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_SWSTBY = 3'd2,
    MODE_HWSTBY = 3'd3,
    MODE_RESET  = 3'd4,
    MODE_SETTLE = 3'd5
  } mode_e;

  // synchronized pin values
  typedef struct packed {
    logic             stbyN;
    logic             nmi;
    logic [IRQ_W-1:0] irq;
  } pins_t;

  // control -> datapath strobes
  typedef struct packed {
    mode_e mode;
    logic  loadSettle;
    logic  clrModStby;
    logic  allowWrite;
  } ctl_t;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int              WIDTH     = 1,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath import lpm_pkg::*; #(
  parameter int NUM_MOD = 6,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstPinN,
  input  logic               stbyPinN,
  input  logic               nmiIn,
  input  logic [IRQ_W-1:0]   irqIn,
  input  logic [CNT_W-1:0]   settleCnt,
  input  logic               modStbyWe,
  input  logic [NUM_MOD-1:0] modStbyWd,
  input  ctl_t               ctl,
  output logic               rstSyncN,
  output pins_t              pinSync,
  output logic               settleDone,
  output logic [NUM_MOD-1:0] modStbyQ,
  output logic               cpuClkEn,
  output logic [NUM_MOD-1:0] modClkEn,
  output logic [NUM_MOD-1:0] modRst,
  output logic               refClkEn,
  output logic               refPartRst,
  output logic               refFullRst,
  output logic               sysClkOe,
  output logic               sysClkHigh,
  output logic               portHiZ
);
  localparam int PIN_W = $bits(pins_t);
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, {(PIN_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // reset pin: asynchronous assertion, synchronized release
  lpm_sync #(.WIDTH(1), .STAGES(2), .RESET_VAL(1'b0)) u_rstSync (
    .clk (clk), .rstN(rstPinN), .d(1'b1), .q(rstSyncN)
  );

  logic [PIN_W-1:0] pinRaw, pinQ;
  assign pinRaw = {stbyPinN, nmiIn, irqIn};

  lpm_sync #(.WIDTH(PIN_W), .STAGES(2), .RESET_VAL(PIN_IDLE)) u_pinSync (
    .clk (clk), .rstN(rstSyncN), .d(pinRaw), .q(pinQ)
  );
  assign pinSync = pins_t'(pinQ);

  // settling counter
  logic [CNT_W-1:0] cntQ;
  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)           cntQ <= '0;
    else if (ctl.loadSettle) cntQ <= (settleCnt == '0) ? CNT_ONE : settleCnt;
    else if (cntQ != '0)     cntQ <= cntQ - CNT_ONE;
  end
  assign settleDone = (cntQ == CNT_ONE);

  // module standby register
  always_ff @(posedge clk or negedge rstSyncN) begin
    if (!rstSyncN)                      modStbyQ <= '0;
    else if (ctl.clrModStby)            modStbyQ <= '0;
    else if (modStbyWe && ctl.allowWrite) modStbyQ <= modStbyWd;
  end

  // output decode
  logic inRun, inSleep, inSw, inSettle, inHw, inRst, modActive;
  assign inRun     = (ctl.mode == MODE_RUN);
  assign inSleep   = (ctl.mode == MODE_SLEEP);
  assign inSw      = (ctl.mode == MODE_SWSTBY);
  assign inSettle  = (ctl.mode == MODE_SETTLE);
  assign inHw      = (ctl.mode == MODE_HWSTBY);
  assign inRst     = (ctl.mode == MODE_RESET);
  assign modActive = inRun | inSleep;

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    assign modClkEn[i] = modActive & ~modStbyQ[i];
    assign modRst[i]   = ~modActive | modStbyQ[i];
  end

  assign cpuClkEn   = inRun;
  assign refClkEn   = modActive;
  assign refPartRst = inSw | inSettle;
  assign refFullRst = inHw | inRst;
  assign sysClkOe   = ~inHw;
  assign sysClkHigh = inSw;
  assign portHiZ    = inHw;
endmodule

// File: rtl/lpm_control.sv
module lpm_control import lpm_pkg::*; (
  input  logic  clk,
  input  logic  rstN,
  input  logic  sleepInsn,
  input  logic  ssbySel,
  input  logic  intPend,
  input  pins_t pinSync,
  input  logic  settleDone,
  output ctl_t  ctl
);
  mode_e modeQ, modeNext;
  logic  loadSettle, hardWake;

  assign hardWake = pinSync.nmi | (|pinSync.irq);

  always_comb begin
    modeNext   = modeQ;
    loadSettle = 1'b0;
    if (!pinSync.stbyN) begin
      modeNext = MODE_HWSTBY;
    end else begin
      case (modeQ)
        MODE_RESET:  modeNext = MODE_RUN;
        MODE_RUN:    if (sleepInsn) modeNext = ssbySel ? MODE_SWSTBY : MODE_SLEEP;
        MODE_SLEEP:  if (intPend | hardWake) modeNext = MODE_RUN;
        MODE_SWSTBY: if (hardWake) begin
                       modeNext   = MODE_SETTLE;
                       loadSettle = 1'b1;
                     end
        MODE_SETTLE: if (settleDone) modeNext = MODE_RUN;
        MODE_HWSTBY: modeNext = MODE_RESET;
        default:     modeNext = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RESET;
    else       modeQ <= modeNext;
  end

  assign ctl.mode       = modeQ;
  assign ctl.loadSettle = loadSettle;
  assign ctl.clrModStby = (modeQ == MODE_RESET);
  assign ctl.allowWrite = (modeQ == MODE_RUN);
endmodule

// File: rtl/lowpower_mode_ctrl.sv
module lowpower_mode_ctrl import lpm_pkg::*; #(
  parameter int NUM_MOD = 6,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstPinN,
  input  logic               stbyPinN,
  input  logic               nmiIn,
  input  logic [IRQ_W-1:0]   irqIn,
  input  logic               intPend,
  input  logic               sleepInsn,
  input  logic               ssbySel,
  input  logic [CNT_W-1:0]   settleCnt,
  input  logic               modStbyWe,
  input  logic [NUM_MOD-1:0] modStbyWd,
  output logic               cpuClkEn,
  output logic [NUM_MOD-1:0] modClkEn,
  output logic [NUM_MOD-1:0] modRst,
  output logic               refClkEn,
  output logic               refPartRst,
  output logic               refFullRst,
  output logic               sysClkOe,
  output logic               sysClkHigh,
  output logic               portHiZ,
  output logic [NUM_MOD-1:0] modStbyQ,
  output logic [2:0]         mode
);
  logic  rstSyncN, settleDone;
  pins_t pinSync;
  ctl_t  ctl;

  lpm_datapath #(.NUM_MOD(NUM_MOD), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstPinN(rstPinN), .stbyPinN(stbyPinN), .nmiIn(nmiIn),
    .irqIn(irqIn), .settleCnt(settleCnt), .modStbyWe(modStbyWe),
    .modStbyWd(modStbyWd), .ctl(ctl), .rstSyncN(rstSyncN), .pinSync(pinSync),
    .settleDone(settleDone), .modStbyQ(modStbyQ), .cpuClkEn(cpuClkEn),
    .modClkEn(modClkEn), .modRst(modRst), .refClkEn(refClkEn),
    .refPartRst(refPartRst), .refFullRst(refFullRst), .sysClkOe(sysClkOe),
    .sysClkHigh(sysClkHigh), .portHiZ(portHiZ)
  );

  lpm_control u_ctl (
    .clk(clk), .rstN(rstSyncN), .sleepInsn(sleepInsn), .ssbySel(ssbySel),
    .intPend(intPend), .pinSync(pinSync), .settleDone(settleDone), .ctl(ctl)
  );

  assign mode = ctl.mode;
endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int NUM_MOD = 6
) (
  input logic               clk,
  input logic               rstPinN,
  input logic               rstSyncN,
  input logic               stbySyncN,
  input logic               nmiSync,
  input logic [2:0]         irqSync,
  input logic               intPend,
  input logic               sleepInsn,
  input logic               ssbySel,
  input logic [2:0]         mode,
  input logic               cpuClkEn,
  input logic [NUM_MOD-1:0] modClkEn,
  input logic [NUM_MOD-1:0] modRst,
  input logic               portHiZ,
  input logic               sysClkOe,
  input logic [NUM_MOD-1:0] modStbyQ
);
  always_ff @(posedge clk) begin
    if (!rstPinN) begin
      a_r1_reset_mode: assert (mode == 3'd4 && modStbyQ == '0);
    end
  end

  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd0 && sleepInsn && !ssbySel && stbySyncN) |=> mode == 3'd1);

  a_r3_sleep_wake: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd1 && stbySyncN && intPend) |=> mode == 3'd0);

  a_r4_swstby_entry: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd0 && sleepInsn && ssbySel && stbySyncN) |=> mode == 3'd2);

  a_r5_swstby_hold: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd2 && stbySyncN && !nmiSync && irqSync == 3'b000) |=> mode == 3'd2);

  a_r6_run_entry: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd0 && $past(mode) != 3'd0) |->
      ($past(mode) == 3'd4 || $past(mode) == 3'd1 || $past(mode) == 3'd5));

  a_r7_hw_entry: assert property (@(posedge clk) disable iff (!rstSyncN)
    !stbySyncN |=> mode == 3'd3);

  a_r7_hw_outputs: assert property (@(posedge clk) disable iff (!rstSyncN)
    mode == 3'd3 |-> (portHiZ && !sysClkOe && modClkEn == '0 && !cpuClkEn));

  a_r8_hw_exit: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode == 3'd3 && stbySyncN) |=> mode == 3'd4);

  a_r9_mod_gating: assert property (@(posedge clk) disable iff (!rstSyncN)
    cpuClkEn |-> (modClkEn == ~modStbyQ && modRst == modStbyQ));

  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rstSyncN)
    (mode != 3'd0 && mode != 3'd4) |=> $stable(modStbyQ));
endmodule

bind lowpower_mode_ctrl lpm_checker #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk(clk), .rstPinN(rstPinN), .rstSyncN(rstSyncN),
  .stbySyncN(pinSync.stbyN), .nmiSync(pinSync.nmi), .irqSync(pinSync.irq),
  .intPend(intPend), .sleepInsn(sleepInsn), .ssbySel(ssbySel), .mode(mode),
  .cpuClkEn(cpuClkEn), .modClkEn(modClkEn), .modRst(modRst),
  .portHiZ(portHiZ), .sysClkOe(sysClkOe), .modStbyQ(modStbyQ)
);

// File: tb/test_lowpower_mode_ctrl.sv
module test_lowpower_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rstPinN = 1'b1, stbyPinN = 1'b1, nmiIn = 1'b0;
  logic [2:0] irqIn = '0;
  logic intPend = 1'b0, sleepInsn = 1'b0, ssbySel = 1'b0, modStbyWe = 1'b0;
  logic [7:0] settleCnt = 8'd4;
  logic [NM-1:0] modStbyWd = '0;
  logic cpuClkEn, refClkEn, refPartRst, refFullRst, sysClkOe, sysClkHigh, portHiZ;
  logic [NM-1:0] modClkEn, modRst, modStbyQ;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowpower_mode_ctrl i_lowpower_mode_ctrl (
    .clk(clk), .rstPinN(rstPinN), .stbyPinN(stbyPinN), .nmiIn(nmiIn),
    .irqIn(irqIn), .intPend(intPend), .sleepInsn(sleepInsn), .ssbySel(ssbySel),
    .settleCnt(settleCnt), .modStbyWe(modStbyWe), .modStbyWd(modStbyWd),
    .cpuClkEn(cpuClkEn), .modClkEn(modClkEn), .modRst(modRst),
    .refClkEn(refClkEn), .refPartRst(refPartRst), .refFullRst(refFullRst),
    .sysClkOe(sysClkOe), .sysClkHigh(sysClkHigh), .portHiZ(portHiZ),
    .modStbyQ(modStbyQ), .mode(mode)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseSleep(input logic sel);
    ssbySel = sel; sleepInsn = 1'b1;
    tick(1);
    sleepInsn = 1'b0;
  endtask

  task automatic writeMod(input logic [NM-1:0] v);
    modStbyWd = v; modStbyWe = 1'b1;
    tick(1);
    modStbyWe = 1'b0;
  endtask

  task automatic t_reset();
    rstPinN = 1'b0;
    tick(2);
    chk("R1", "mode in reset", 32'(mode), 32'd4);
    chk("R1", "cpuClkEn", 32'(cpuClkEn), 32'd0);
    chk("R1", "modRst", 32'(modRst), 32'h3f);
    chk("R1", "refFullRst", 32'(refFullRst), 32'd1);
    chk("R1", "modStbyQ", 32'(modStbyQ), 32'd0);
    rstPinN = 1'b1;
    tick(2);
    chk("R1", "mode before 3rd edge", 32'(mode), 32'd4);
    tick(1);
    chk("R1", "mode run", 32'(mode), 32'd0);
    chk("R1", "cpuClkEn run", 32'(cpuClkEn), 32'd1);
  endtask

  task automatic t_sleep();
    pulseSleep(1'b0);
    chk("R2", "mode sleep", 32'(mode), 32'd1);
    chk("R2", "cpuClkEn", 32'(cpuClkEn), 32'd0);
    chk("R2", "modClkEn", 32'(modClkEn), 32'h3f);
    chk("R2", "refClkEn", 32'(refClkEn), 32'd1);
    chk("R2", "sysClk oe/high", 32'({sysClkOe, sysClkHigh}), 32'b10);
    tick(3);
    chk("R3", "no wake stays sleep", 32'(mode), 32'd1);
    intPend = 1'b1;
    tick(1);
    intPend = 1'b0;
    chk("R3", "intPend wake", 32'(mode), 32'd0);
    pulseSleep(1'b0);
    irqIn = 3'b010;
    tick(2);
    chk("R3", "irq before sync", 32'(mode), 32'd1);
    tick(1);
    chk("R3", "irq wake", 32'(mode), 32'd0);
    irqIn = '0;
    tick(3);
  endtask

  task automatic t_swstby();
    settleCnt = 8'd4;
    pulseSleep(1'b1);
    chk("R4", "mode swstby", 32'(mode), 32'd2);
    chk("R4", "modClkEn", 32'(modClkEn), 32'd0);
    chk("R4", "modRst", 32'(modRst), 32'h3f);
    chk("R4", "ref part/full", 32'({refPartRst, refFullRst}), 32'b10);
    chk("R4", "sysClk oe/high", 32'({sysClkOe, sysClkHigh}), 32'b11);
    chk("R4", "cpu/hiz", 32'({cpuClkEn, portHiZ}), 32'b00);
    intPend = 1'b1; sleepInsn = 1'b1;
    tick(4);
    intPend = 1'b0; sleepInsn = 1'b0;
    chk("R5", "intPend ignored", 32'(mode), 32'd2);
    nmiIn = 1'b1;
    tick(3);
    nmiIn = 1'b0;
    chk("R6", "settling entered", 32'(mode), 32'd5);
    tick(3);
    chk("R6", "still settling n=4", 32'(mode), 32'd5);
    tick(1);
    chk("R6", "run after 4", 32'(mode), 32'd0);
    tick(2);
    settleCnt = 8'd0;
    pulseSleep(1'b1);
    irqIn = 3'b100;
    tick(3);
    irqIn = '0;
    chk("R6", "settling n=0", 32'(mode), 32'd5);
    tick(1);
    chk("R6", "run after 1", 32'(mode), 32'd0);
    ssbySel = 1'b0;
    tick(2);
  endtask

  task automatic t_modstby();
    writeMod(6'b100101);
    chk("R9", "modStbyQ", 32'(modStbyQ), 32'h25);
    chk("R9", "modClkEn run", 32'(modClkEn), 32'h1a);
    chk("R9", "modRst run", 32'(modRst), 32'h25);
    chk("R9", "cpu runs", 32'(cpuClkEn), 32'd1);
    pulseSleep(1'b0);
    chk("R9", "modClkEn sleep", 32'(modClkEn), 32'h1a);
    writeMod(6'b111111);
    chk("R10", "write in sleep ignored", 32'(modStbyQ), 32'h25);
    intPend = 1'b1;
    tick(1);
    intPend = 1'b0;
    writeMod(6'b000000);
    chk("R9", "modClkEn restored", 32'(modClkEn), 32'h3f);
    chk("R9", "modRst released", 32'(modRst), 32'd0);
  endtask

  task automatic t_hwstby();
    writeMod(6'b000011);
    stbyPinN = 1'b0;
    tick(2);
    chk("R7", "before sync", 32'(mode), 32'd0);
    tick(1);
    chk("R7", "mode hw", 32'(mode), 32'd3);
    chk("R7", "portHiZ", 32'(portHiZ), 32'd1);
    chk("R7", "sysClkOe", 32'(sysClkOe), 32'd0);
    chk("R7", "refFullRst", 32'(refFullRst), 32'd1);
    chk("R7", "clocks off", 32'({cpuClkEn, modClkEn}), 32'd0);
    nmiIn = 1'b1; intPend = 1'b1; irqIn = 3'b001;
    tick(4);
    chk("R8", "wakes ignored", 32'(mode), 32'd3);
    nmiIn = 1'b0; intPend = 1'b0; irqIn = '0;
    tick(2);
    stbyPinN = 1'b1;
    tick(2);
    chk("R8", "before sync", 32'(mode), 32'd3);
    tick(1);
    chk("R8", "reset state", 32'(mode), 32'd4);
    tick(1);
    chk("R8", "run", 32'(mode), 32'd0);
    chk("R8", "modStbyQ cleared", 32'(modStbyQ), 32'd0);
    pulseSleep(1'b0);
    stbyPinN = 1'b0;
    tick(3);
    chk("R7", "hw from sleep", 32'(mode), 32'd3);
    stbyPinN = 1'b1;
    tick(4);
    chk("R8", "back to run", 32'(mode), 32'd0);
  endtask

  task automatic t_priority();
    pulseSleep(1'b1);
    nmiIn = 1'b1; stbyPinN = 1'b0;
    tick(3);
    chk("R11", "pin beats nmi", 32'(mode), 32'd3);
    nmiIn = 1'b0; stbyPinN = 1'b1; ssbySel = 1'b0;
    tick(4);
    chk("R11", "back to run", 32'(mode), 32'd0);
    writeMod(6'b110000);
    stbyPinN = 1'b0;
    tick(3);
    rstPinN = 1'b0;
    tick(1);
    chk("R11", "reset beats pin", 32'(mode), 32'd4);
    chk("R1", "reset clears modStby", 32'(modStbyQ), 32'd0);
    stbyPinN = 1'b1; rstPinN = 1'b1;
    tick(3);
    chk("R1", "run after reset", 32'(mode), 32'd0);
  endtask

  initial begin
    tick(4);
    t_reset();
    t_sleep();
    t_swstby();
    t_modstby();
    t_hwstby();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule